// File: doc/BRIEF.md
# I2C Byte-Stepped Master Controller

This block is an I2C master that moves one byte per software command. Software writes a five-bit command word. The word can ask for a Start condition, the transfer of one byte, a Stop after the next data byte, a NACK policy for received bytes, or an immediate Stop with no data (master abort). The first byte after any Start is the address byte. It is always shifted out, and its least significant bit sets the direction of the data bytes that follow. After each byte and its acknowledge bit, the controller clears the byte command and parks with SCL pulled low. It stays there until software issues the next command.

Both bus lines are open-drain. The block drives a pull-down enable for each line and reads SDA back through a separate input. Bus timing comes from a fixed divider. The divider marks quarter periods of SCL, and SDA moves only in the second quarter, while SCL is low. The only exceptions are the Start and Stop edges. Command sequences that make no sense on the bus raise a sticky error flag instead of touching the lines.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset both pull-downs are off, the command readback is 0, and rx_byte_o, ack_nak_o and bus_err_o are 0.
- R2: A Start request produces one Start condition, which is SDA falling while SCL is high. SCL is then held low, and the Start command bit reads 0 again once the condition is complete.
- R3: The byte after a Start is transmitted MSB first as an address, and its bit 0 set to 1 selects reading. On every transmitted byte, the level of SDA during the ninth clock is captured into ack_nak_o, where 1 means NACK.
- R4: The transfer command bit clears after the acknowledge bit of its byte. SCL then stays low, with no further SCL edges, until a new command arrives.
- R5: In read direction the master releases SDA for eight clocks and presents the byte MSB first on rx_byte_o. On the ninth clock it pulls SDA low when the NACK bit is 0 and leaves SDA released when the NACK bit is 1.
- R6: A Stop request takes effect only after the next data byte, not after an address byte. A Stop condition is SDA rising while SCL is high. After the Stop the bus is released and the Stop bit reads 0.
- R7: Master abort with the transfer bit clear produces a Stop with exactly one SCL rising edge and no data byte. The abort bit reads 0 afterwards.
- R8: Master abort right after a read-direction address byte, before any data byte, is refused. bus_err_o is set, the abort bit clears, and SCL stays low with no Stop.
- R9: A transfer, Stop or abort request while the bus is idle and no Start is pending sets bus_err_o, clears those bits, and causes no SCL edge. The next accepted Start clears bus_err_o.
- R10: A Start request while the bus is held low produces a repeated Start. The byte after it is again treated as an address.
- R11: The command word bit positions are: bit 0 Start, bit 1 Stop, bit 2 transfer, bit 3 NACK, bit 4 abort. Writing 0 to bit 0, 1, 2 or 4 has no effect. Bit 3 takes the written value.
- R12: Within a byte, SCL rising edges are 4*QTR_CLKS system clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command word write strobe |
| cmd_wdata_i | input | 5 | Command word to write |
| cmd_rdata_o | output | 5 | Current command word |
| tx_byte_i | input | 8 | Byte to transmit (address or data) |
| rx_byte_o | output | 8 | Last received byte |
| ack_nak_o | output | 1 | Acknowledge seen on last transmitted byte, 1 = NACK |
| bus_err_o | output | 1 | Sticky illegal-command flag |
| sda_i | input | 1 | Sampled SDA line level |
| scl_pd_o | output | 1 | SCL pull-down enable |
| sda_pd_o | output | 1 | SDA pull-down enable |

## Verification
Two events can land in the same cycle. The first is the completion of a byte whose Stop is pending; the cycle that clears the transfer bit is also the cycle that starts the Stop. The bench provokes this by writing Stop together with the transfer bit. It judges the result by counting how many bytes the slave model has logged at the instant it sees the Stop edge. The second is a software write landing while the engine is busy. It is provoked by writing an all-zero word one cycle after a transfer starts, and it is judged by the transfer bit still reading 1.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_START,
    ST_BYTE,
    ST_STOP
  } i2cm_state_e;

  // bit 0 start, 1 stop, 2 tb, 3 nack, 4 ma
  typedef struct packed {
    logic ma;
    logic nack;
    logic tb;
    logic stop;
    logic start;
  } i2cm_cmd_t;
endpackage

// File: rtl/i2cm_div.sv
module i2cm_div #(
  parameter int QTR_CLKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = $clog2(QTR_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(QTR_CLKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/i2cm_shreg.sv
module i2cm_shreg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic         msb_o,
  output logic [W-1:0] val_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= load_val_i;
    else if (shift_i) sh_q <= {sh_q[W-2:0], bit_i};
  end

  assign msb_o = sh_q[W-1];
  assign val_o = sh_q;
endmodule

// File: rtl/i2cm_cmdreg.sv
module i2cm_cmdreg
  import i2cm_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      we_i,
  input  i2cm_cmd_t wdata_i,
  input  i2cm_cmd_t clr_i,
  output i2cm_cmd_t q_o
);
  i2cm_cmd_t q;
  i2cm_cmd_t set;

  // ones set the action bits, zeros are ignored; nack is plain storage
  always_comb begin
    set = we_i ? wdata_i : '0;
    set.nack = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else begin
      q.start <= (q.start & ~clr_i.start) | set.start;
      q.stop  <= (q.stop  & ~clr_i.stop)  | set.stop;
      q.tb    <= (q.tb    & ~clr_i.tb)    | set.tb;
      q.ma    <= (q.ma    & ~clr_i.ma)    | set.ma;
      q.nack  <= we_i ? wdata_i.nack : (q.nack & ~clr_i.nack);
    end
  end

  assign q_o = q;
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter int QTR_CLKS = 4,
  parameter int BYTE_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [4:0]        cmd_wdata_i,
  output logic [4:0]        cmd_rdata_o,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              ack_nak_o,
  output logic              bus_err_o,
  input  logic              sda_i,
  output logic              scl_pd_o,
  output logic              sda_pd_o
);
  localparam int BCW = $clog2(BYTE_W + 2);
  localparam logic [BCW-1:0] ACK_BIT = BCW'(BYTE_W);

  i2cm_state_e state_q, state_d;
  i2cm_cmd_t   cmd_q, clr;
  logic [1:0]  qtr_q;
  logic [BCW-1:0] bit_q;
  logic rd_q, addr_ph_q, got_data_q, sda_hold_q, bit_pd_q, samp_q;
  logic ack_nak_q, bus_err_q;
  logic [BYTE_W-1:0] rx_q, sh_val;
  logic sh_msb, tick, run, tx_mode, cur_pd;
  logic err_set, err_clr, byte_go, start_done, bit_end, byte_end, qtr_end;

  assign run     = (state_q == ST_START) || (state_q == ST_BYTE) || (state_q == ST_STOP);
  assign qtr_end = tick && (qtr_q == 2'd3);
  assign tx_mode = addr_ph_q || !rd_q;

  i2cm_div #(.QTR_CLKS(QTR_CLKS)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .tick_o(tick)
  );

  i2cm_cmdreg u_cmd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cmd_we_i),
    .wdata_i(i2cm_cmd_t'(cmd_wdata_i)),
    .clr_i  (clr),
    .q_o    (cmd_q)
  );

  i2cm_shreg #(.W(BYTE_W)) u_sh (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (byte_go),
    .load_val_i(tx_byte_i),
    .shift_i   (bit_end && (bit_q != ACK_BIT)),
    .bit_i     (samp_q),
    .msb_o     (sh_msb),
    .val_o     (sh_val)
  );

  // pull-down wanted for the current bit from its second quarter on
  always_comb begin
    if (bit_q == ACK_BIT) cur_pd = tx_mode ? 1'b0 : ~cmd_q.nack;
    else                  cur_pd = tx_mode ? ~sh_msb : 1'b0;
  end

  always_comb begin
    state_d    = state_q;
    clr        = '0;
    err_set    = 1'b0;
    err_clr    = 1'b0;
    byte_go    = 1'b0;
    start_done = 1'b0;
    bit_end    = 1'b0;
    byte_end   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_q.start) begin
          state_d = ST_START;
          err_clr = 1'b1;
        end else if (cmd_q.tb || cmd_q.ma || cmd_q.stop) begin
          err_set  = 1'b1;
          clr.tb   = 1'b1;
          clr.ma   = 1'b1;
          clr.stop = 1'b1;
        end
      end
      ST_HOLD: begin
        if (cmd_q.start) begin
          state_d = ST_START;
          err_clr = 1'b1;
        end else if (cmd_q.ma && !cmd_q.tb) begin
          if (rd_q && !got_data_q) begin
            err_set = 1'b1;
            clr.ma  = 1'b1;
          end else begin
            state_d = ST_STOP;
          end
        end else if (cmd_q.tb) begin
          state_d = ST_BYTE;
          byte_go = 1'b1;
        end
      end
      ST_START: begin
        if (qtr_end) begin
          state_d    = ST_HOLD;
          clr.start  = 1'b1;
          start_done = 1'b1;
        end
      end
      ST_BYTE: begin
        if (qtr_end) begin
          bit_end = 1'b1;
          if (bit_q == ACK_BIT) begin
            byte_end = 1'b1;
            clr.tb   = 1'b1;
            state_d  = (cmd_q.stop && !addr_ph_q) ? ST_STOP : ST_HOLD;
          end
        end
      end
      ST_STOP: begin
        if (qtr_end) begin
          state_d  = ST_IDLE;
          clr.stop = 1'b1;
          clr.ma   = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      qtr_q      <= '0;
      bit_q      <= '0;
      rd_q       <= 1'b0;
      addr_ph_q  <= 1'b0;
      got_data_q <= 1'b0;
      sda_hold_q <= 1'b0;
      bit_pd_q   <= 1'b0;
      samp_q     <= 1'b0;
      ack_nak_q  <= 1'b0;
      bus_err_q  <= 1'b0;
      rx_q       <= '0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q) qtr_q <= '0;
      else if (tick)          qtr_q <= qtr_q + 1'b1;
      if (err_set)      bus_err_q <= 1'b1;
      else if (err_clr) bus_err_q <= 1'b0;
      if (start_done) begin
        addr_ph_q  <= 1'b1;
        got_data_q <= 1'b0;
        sda_hold_q <= 1'b1;
      end
      if (byte_go) begin
        bit_q    <= '0;
        bit_pd_q <= sda_hold_q;
        if (addr_ph_q) rd_q <= tx_byte_i[0];
      end
      if (state_q == ST_BYTE && tick && qtr_q == 2'd2) samp_q <= sda_i;
      if (bit_end) begin
        bit_q    <= bit_q + 1'b1;
        bit_pd_q <= cur_pd;
      end
      if (byte_end) begin
        sda_hold_q <= cur_pd;
        addr_ph_q  <= 1'b0;
        if (!addr_ph_q) got_data_q <= 1'b1;
        if (tx_mode) ack_nak_q <= samp_q;
        else         rx_q      <= sh_val;
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_HOLD: begin
        scl_pd_o = 1'b1;
        sda_pd_o = sda_hold_q;
      end
      ST_START: begin
        scl_pd_o = (qtr_q == 2'd0);
        sda_pd_o = qtr_q[1];
      end
      ST_BYTE: begin
        scl_pd_o = ~qtr_q[1];
        sda_pd_o = (qtr_q == 2'd0) ? bit_pd_q : cur_pd;
      end
      ST_STOP: begin
        scl_pd_o = ~qtr_q[1];
        sda_pd_o = (qtr_q != 2'd3);
      end
      default: begin
        scl_pd_o = 1'b0;
        sda_pd_o = 1'b0;
      end
    endcase
  end

  assign cmd_rdata_o = cmd_q;
  assign rx_byte_o   = rx_q;
  assign ack_nak_o   = ack_nak_q;
  assign bus_err_o   = bus_err_q;
endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cmd_we_i,
  input logic cmd_start_i,
  input logic cmd_stop_i,
  input logic cmd_tb_i,
  input logic cmd_ma_i,
  input logic scl_pd_o,
  input logic sda_pd_o,
  input logic bus_err_o
);
  // R2
  start_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_pd_o && $past(!scl_pd_o) && $rose(sda_pd_o)) |-> $past(cmd_start_i));

  // R6
  stop_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_pd_o && $past(!scl_pd_o) && $fell(sda_pd_o)) |-> $past(cmd_stop_i || cmd_ma_i));

  // R4
  scl_park_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_pd_o && !cmd_we_i && !cmd_start_i && !cmd_stop_i && !cmd_tb_i && !cmd_ma_i)
      |=> scl_pd_o);

  // R9
  err_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_err_o) |-> $past(cmd_start_i));
endmodule

bind i2c_byte_master i2cm_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_we_i   (cmd_we_i),
  .cmd_start_i(cmd_rdata_o[0]),
  .cmd_stop_i (cmd_rdata_o[1]),
  .cmd_tb_i   (cmd_rdata_o[2]),
  .cmd_ma_i   (cmd_rdata_o[4]),
  .scl_pd_o   (scl_pd_o),
  .sda_pd_o   (sda_pd_o),
  .bus_err_o  (bus_err_o)
);

// File: tb/sim_i2c_byte_master.sv
`timescale 1ns/1ps
module sim_i2c_byte_master;
  localparam int QTR = 4;
  localparam logic [4:0] C_S = 5'h01, C_P = 5'h02, C_T = 5'h04, C_N = 5'h08, C_M = 5'h10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       we = 1'b0;
  logic [4:0] wd = '0;
  logic [4:0] cmd_rd;
  logic [7:0] tx = '0;
  logic [7:0] rx;
  logic ack_nak, bus_err, scl_pd, sda_pd;
  logic slv_pd = 1'b0;
  wire  scl_l = ~scl_pd;
  wire  sda_l = ~(sda_pd | slv_pd);

  i2c_byte_master #(.QTR_CLKS(QTR)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(we), .cmd_wdata_i(wd), .cmd_rdata_o(cmd_rd),
    .tx_byte_i(tx), .rx_byte_o(rx), .ack_nak_o(ack_nak), .bus_err_o(bus_err),
    .sda_i(sda_l), .scl_pd_o(scl_pd), .sda_pd_o(sda_pd)
  );

  int nchk = 0, nfail = 0;
  int bitn = 0, wcnt = 0, n_start = 0, n_stop = 0, n_rise = 0, n_fall = 0, wcnt_at_stop = 0;
  int cyc = 0, last_rise = 0, rise_delta = 0;
  logic addr_s = 1'b0, rd_s = 1'b0, mack = 1'b0, scl_p = 1'b1, sda_p = 1'b1;
  logic [7:0] rcv = '0, saddr = '0, slv_rdata = 8'hA5;
  logic [7:0] wlog [0:15];

  // behavioural slave at address 0x2A; NACKs a written 0xFF
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (scl_l && scl_p && sda_p && !sda_l) begin
        n_start++; bitn = 0; addr_s = 1'b1; rd_s = 1'b0; slv_pd = 1'b0;
      end else if (scl_l && scl_p && !sda_p && sda_l) begin
        n_stop++; wcnt_at_stop = wcnt; slv_pd = 1'b0;
      end
      if (scl_l && !scl_p) begin
        n_rise++; rise_delta = cyc - last_rise; last_rise = cyc;
        if (bitn < 8) begin rcv = {rcv[6:0], sda_l}; bitn++; end
        else if (bitn == 8) begin mack = sda_l; bitn = 9; end
      end
      if (!scl_l && scl_p) begin
        n_fall++;
        if (bitn == 8) begin
          if (addr_s) begin saddr = rcv; rd_s = rcv[0]; slv_pd = (rcv[7:1] == 7'h2A); end
          else if (!rd_s) begin wlog[wcnt % 16] = rcv; wcnt++; slv_pd = (rcv != 8'hFF); end
          else slv_pd = 1'b0;
        end else if (bitn == 9) begin
          bitn = 0;
          slv_pd = (rd_s && (addr_s || !mack)) ? ~slv_rdata[7] : 1'b0;
          addr_s = 1'b0;
        end else if (bitn >= 1 && bitn < 8 && rd_s && !addr_s) begin
          slv_pd = ~slv_rdata[7-bitn];
        end
      end
      scl_p = scl_l; sda_p = sda_l;
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic cmd(input logic [4:0] v);
    @(negedge clk); we = 1'b1; wd = v;
    @(negedge clk); we = 1'b0; wd = '0;
  endtask

  task automatic wait_clr(input int b);
    int n = 0;
    while (cmd_rd[b] && n < 3000) begin @(negedge clk); n++; end
  endtask

  task automatic wait_idle();
    int n = 0;
    while ((scl_pd || sda_pd || cmd_rd[1] || cmd_rd[4]) && n < 3000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 scl", scl_pd, 0); chk("R1 sda", sda_pd, 0); chk("R1 cmd", cmd_rd, 0);
    chk("R1 rx", rx, 0); chk("R1 ack", ack_nak, 0); chk("R1 err", bus_err, 0);
  endtask

  task automatic t_write();
    int r0;
    cmd(C_S); wait_clr(0);
    chk("R2 starts", n_start, 1); chk("R2 held", scl_pd, 1); chk("R2 bit", cmd_rd[0], 0);
    tx = 8'h54; cmd(C_T); cmd(5'h00);
    chk("R11 tb kept", cmd_rd[2], 1);
    wait_clr(2);
    chk("R3 addr", saddr, 8'h54); chk("R3 ack", ack_nak, 0);
    r0 = n_rise; repeat (40) @(negedge clk);
    chk("R4 no edge", n_rise, r0); chk("R4 scl low", scl_pd, 1);
    tx = 8'h3C; cmd(C_T); wait_clr(2);
    chk("R3 data", wlog[0], 8'h3C); chk("R3 ack", ack_nak, 0);
    chk("R12 period", rise_delta, 4*QTR);
    cmd(C_N); chk("R11 nack only", cmd_rd, 5'h08);
    tx = 8'hFF; cmd(C_T | C_N); wait_clr(2);
    chk("R3 nak", ack_nak, 1); chk("R3 data", wlog[1], 8'hFF);
    tx = 8'h81; cmd(C_P | C_T);
    chk("R6 not early", n_stop, 0);
    wait_idle();
    chk("R6 stops", n_stop, 1); chk("R6 after byte", wcnt_at_stop, 3);
    chk("R6 data", wlog[2], 8'h81); chk("R6 bit", cmd_rd[1], 0);
    chk("R6 released", {scl_pd, sda_pd}, 0);
  endtask

  task automatic t_read();
    int f0;
    f0 = n_fall;
    cmd(C_T); repeat (4) @(negedge clk);
    chk("R9 err", bus_err, 1); chk("R9 tb clr", cmd_rd[2], 0); chk("R9 no edge", n_fall, f0);
    cmd(C_S); wait_clr(0);
    chk("R9 err cleared", bus_err, 0);
    slv_rdata = 8'hA5;
    tx = 8'h55; cmd(C_T); wait_clr(2);
    chk("R3 rd addr", saddr, 8'h55); chk("R3 ack", ack_nak, 0);
    cmd(C_T); wait_clr(2);
    chk("R5 rx", rx, 8'hA5); chk("R5 ack", mack, 0);
    slv_rdata = 8'hC3;
    cmd(C_P | C_T | C_N); wait_idle();
    chk("R5 rx", rx, 8'hC3); chk("R5 nak", mack, 1); chk("R6 stops", n_stop, 2);
  endtask

  task automatic t_abort();
    int s0, p0, r0, w0;
    cmd(C_S); wait_clr(0);
    tx = 8'h55; cmd(C_T); wait_clr(2);
    p0 = n_stop;
    cmd(C_M); repeat (4) @(negedge clk);
    chk("R8 err", bus_err, 1); chk("R8 ma clr", cmd_rd[4], 0);
    chk("R8 held", scl_pd, 1); chk("R8 no stop", n_stop, p0);
    s0 = n_start;
    cmd(C_S); wait_clr(0);
    chk("R10 rstart", n_start, s0 + 1); chk("R10 err", bus_err, 0);
    tx = 8'h54; cmd(C_T); wait_clr(2);
    chk("R10 addr", saddr, 8'h54); chk("R10 ack", ack_nak, 0);
    w0 = wcnt; r0 = n_rise;
    cmd(C_M); wait_idle();
    chk("R7 stop", n_stop, p0 + 1); chk("R7 one rise", n_rise, r0 + 1);
    chk("R7 no data", wcnt, w0); chk("R7 ma clr", cmd_rd[4], 0);
  endtask

  initial begin
    fork
      begin t_reset(); t_write(); t_read(); t_abort(); end
      begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog act=150000 exp=less");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule